// File: doc/BRIEF.md
# Instruction Translation Cache with Page-and-Identifier Invalidation

This block is a small, fully associative cache of instruction-side address translations. Each entry maps a virtual page to a physical page. Each entry also carries an 8-bit address-space identifier and a global flag. A combinational lookup port takes a virtual page number and the current identifier. It returns a hit flag and the matching physical page in the same cycle. A fill port writes one new translation per cycle. The entry it writes is the lowest free slot, or a round-robin victim when every slot is occupied.

A maintenance port removes translations selectively. A one-cycle request carries a 32-bit operand word:

- The upper bits name the virtual page.
- The low byte names the identifier.
- The bits between them are reserved and ignored.

The operation removes every non-global entry that matches both the page and the identifier. It also removes every global entry that matches the page, whatever identifier that entry carries. The operation affects only this cache. A one-cycle done pulse reports completion, and a lookup in that cycle already sees the result.

Top module: `instr_tlb`

## Requirements
- R1: The invalidate operand is decoded as virtual page = operand[31:12] and identifier = operand[7:0].
- R2: Operand bits [11:8] are ignored: setting them to any value does not change which entries are removed.
- R3: A non-global entry is removed only when both its page and its identifier equal the operand fields. Entries matching only one of the two stay valid.
- R4: A global entry whose page equals the operand page is removed, whatever its stored identifier and whatever the operand identifier.
- R5: All entries satisfying the match are removed at the same clock edge, including duplicates of the same page and identifier.
- R6: Lookup hits when a valid entry has the requested page and is either global or carries the requested identifier. On several hits, the physical page of the lowest-index entry is returned. Lookup is combinational.
- R7: A fill writes the lowest-index invalid entry. When all entries are valid, it writes the entry named by a victim pointer. The pointer starts at 0 after reset and advances by one, wrapping, only on fills that use it.
- R8: An invalidate request sampled at edge k is applied at edge k+1. invDone is high for exactly the cycle after edge k+1, and lookups in that cycle see the post-invalidate contents.
- R9: An invalidate request presented in the cycle immediately after an accepted request is ignored.
- R10: A fill in the same cycle as an invalidate being applied is written after the removal, so the filled translation survives even if it matches the operand.
- R11: A synchronous reset clears all valid bits, the victim pointer and invDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lookupVpn | input | 20 | Virtual page number to translate |
| lookupAsid | input | 8 | Current address-space identifier |
| lookupHit | output | 1 | Translation found |
| lookupPpn | output | 20 | Physical page of the hit entry |
| fillValid | input | 1 | Write a new translation this cycle |
| fillVpn | input | 20 | Virtual page of the new entry |
| fillPpn | input | 20 | Physical page of the new entry |
| fillAsid | input | 8 | Identifier of the new entry |
| fillGlobal | input | 1 | New entry ignores the identifier |
| invReq | input | 1 | Invalidate request, one cycle |
| invOperand | input | 32 | Invalidate operand word |
| invDone | output | 1 | One-cycle completion pulse |

## Verification
A wrong valid bit, stored tag or identifier decode is visible at the lookup port no later than the done cycle of the invalidate that should have changed it. A stale hit or a missing hit shows there directly. A wrong victim choice stays hidden until a later lookup of the overwritten page. For that reason, the stimulus refills a full cache repeatedly and probes the displaced pages at once. A wrong done timing is visible on the first cycle after the apply edge.

// File: rtl/itlb_pkg.sv
package itlb_pkg;

  typedef struct packed {
    logic capture;
    logic apply;
    logic fill;
  } itlbStrobes_t;

endpackage

// File: rtl/itlb_ctrl.sv
module itlb_ctrl
  import itlb_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         invReq,
  input  logic         fillValid,
  output itlbStrobes_t strb,
  output logic         invDone
);

  typedef enum logic {ST_IDLE, ST_APPLY} ctrlState_t;

  ctrlState_t state;
  ctrlState_t stateNext;

  always_comb begin
    strb.capture = invReq && (state == ST_IDLE);
    strb.apply   = (state == ST_APPLY);
    strb.fill    = fillValid;
    stateNext    = strb.capture ? ST_APPLY : ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      invDone <= 1'b0;
    end else begin
      state   <= stateNext;
      invDone <= strb.apply;
    end
  end

  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    invDone |=> !invDone);

  // R8: a done pulse always traces back to a request two cycles earlier
  a_r8_done_from_req: assert property (@(posedge clk) disable iff (rst)
    $rose(invDone) |-> $past(invReq, 2));

  // R9: the apply phase lasts exactly one cycle, so a request in it is dropped
  a_r9_apply_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_APPLY) |=> (state == ST_IDLE));

  // R11: reset returns control to idle with done low
  a_r11_ctrl_reset: assert property (@(posedge clk)
    rst |=> (!invDone && state == ST_IDLE));

endmodule

// File: rtl/itlb_datapath.sv
module itlb_datapath
  import itlb_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int OP_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PPN_W     = 20,
  parameter int ASID_W    = 8,
  localparam int VPN_W    = OP_W - PAGE_BITS,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
)(
  input  logic               clk,
  input  logic               rst,
  input  itlbStrobes_t       strb,
  input  logic [OP_W-1:0]    invOperand,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [PPN_W-1:0]   fillPpn,
  input  logic [ASID_W-1:0]  fillAsid,
  input  logic               fillGlobal,
  input  logic [VPN_W-1:0]   lookupVpn,
  input  logic [ASID_W-1:0]  lookupAsid,
  output logic               lookupHit,
  output logic [PPN_W-1:0]   lookupPpn
);

  logic [ENTRIES-1:0] validQ;
  logic [VPN_W-1:0]   vpnQ    [ENTRIES];
  logic [PPN_W-1:0]   ppnQ    [ENTRIES];
  logic [ASID_W-1:0]  asidQ   [ENTRIES];
  logic               globalQ [ENTRIES];

  logic [VPN_W-1:0]   opVpnQ;
  logic [ASID_W-1:0]  opAsidQ;
  logic [IDX_W-1:0]   rrPtrQ;

  logic [ENTRIES-1:0] invHitVec;
  logic [ENTRIES-1:0] lookHitVec;
  logic               freeFound;
  logic [IDX_W-1:0]   freeIdx;
  logic [IDX_W-1:0]   victimIdx;

  // Operand decode: page on top, identifier in the low byte, gap ignored
  logic [VPN_W-1:0]  opVpnD;
  logic [ASID_W-1:0] opAsidD;
  logic              unusedOpBits;

  assign opVpnD       = invOperand[OP_W-1:PAGE_BITS];
  assign opAsidD      = invOperand[ASID_W-1:0];
  assign unusedOpBits = ^invOperand[PAGE_BITS-1:ASID_W];

  function automatic logic tagMatch(
    input logic              valid,
    input logic [VPN_W-1:0]  entVpn,
    input logic [ASID_W-1:0] entAsid,
    input logic              entGlobal,
    input logic [VPN_W-1:0]  keyVpn,
    input logic [ASID_W-1:0] keyAsid
  );
    return valid && (entVpn == keyVpn) && (entGlobal || (entAsid == keyAsid));
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    assign invHitVec[g]  = tagMatch(validQ[g], vpnQ[g], asidQ[g], globalQ[g],
                                    opVpnQ, opAsidQ);
    assign lookHitVec[g] = tagMatch(validQ[g], vpnQ[g], asidQ[g], globalQ[g],
                                    lookupVpn, lookupAsid);
  end

  // Lowest free slot
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validQ[i]) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
  end

  assign victimIdx = freeFound ? freeIdx : rrPtrQ;

  // Lookup: lowest matching index wins
  always_comb begin
    lookupHit = |lookHitVec;
    lookupPpn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lookHitVec[i]) lookupPpn = ppnQ[i];
    end
  end

  // Control state: valid bits, victim pointer, captured operand
  always_ff @(posedge clk) begin
    if (rst) begin
      validQ  <= '0;
      rrPtrQ  <= '0;
      opVpnQ  <= '0;
      opAsidQ <= '0;
    end else begin
      if (strb.capture) begin
        opVpnQ  <= opVpnD;
        opAsidQ <= opAsidD;
      end
      if (strb.fill && !freeFound) begin
        rrPtrQ <= (rrPtrQ == IDX_W'(ENTRIES - 1)) ? '0 : rrPtrQ + 1'b1;
      end
      for (int i = 0; i < ENTRIES; i++) begin
        if (strb.apply && invHitVec[i]) validQ[i] <= 1'b0;
        if (strb.fill && (victimIdx == IDX_W'(i))) validQ[i] <= 1'b1;
      end
    end
  end

  // Entry payload: no reset needed, qualified by valid
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (!rst && strb.fill && (victimIdx == IDX_W'(i))) begin
        vpnQ[i]    <= fillVpn;
        ppnQ[i]    <= fillPpn;
        asidQ[i]   <= fillAsid;
        globalQ[i] <= fillGlobal;
      end
    end
  end

  // R3 R4 R5: after an apply with no competing fill, nothing still matches
  a_r5_all_cleared: assert property (@(posedge clk) disable iff (rst)
    (strb.apply && !strb.fill) |=> (invHitVec == '0));

  // R7 R10: the filled slot is valid on the next cycle, even across an apply
  a_r10_fill_survives: assert property (@(posedge clk) disable iff (rst)
    strb.fill |=> validQ[$past(victimIdx)]);

  // R7: the victim pointer only moves on a fill into a full cache
  a_r7_ptr_stable: assert property (@(posedge clk) disable iff (rst)
    !(strb.fill && !freeFound) |=> $stable(rrPtrQ));

  // R6: an empty cache never hits
  a_r6_empty_miss: assert property (@(posedge clk) disable iff (rst)
    (validQ == '0) |-> !lookupHit);

  // R11: reset empties the cache and rewinds the pointer
  a_r11_dp_reset: assert property (@(posedge clk)
    rst |=> (validQ == '0 && rrPtrQ == '0));

endmodule

// File: rtl/instr_tlb.sv
module instr_tlb
  import itlb_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int OP_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PPN_W     = 20,
  parameter int ASID_W    = 8,
  localparam int VPN_W    = OP_W - PAGE_BITS
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [VPN_W-1:0]  lookupVpn,
  input  logic [ASID_W-1:0] lookupAsid,
  output logic              lookupHit,
  output logic [PPN_W-1:0]  lookupPpn,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic              fillGlobal,
  input  logic              invReq,
  input  logic [OP_W-1:0]   invOperand,
  output logic              invDone
);

  itlbStrobes_t strb;

  itlb_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .invReq    (invReq),
    .fillValid (fillValid),
    .strb      (strb),
    .invDone   (invDone)
  );

  itlb_datapath #(
    .ENTRIES   (ENTRIES),
    .OP_W      (OP_W),
    .PAGE_BITS (PAGE_BITS),
    .PPN_W     (PPN_W),
    .ASID_W    (ASID_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .invOperand (invOperand),
    .fillVpn    (fillVpn),
    .fillPpn    (fillPpn),
    .fillAsid   (fillAsid),
    .fillGlobal (fillGlobal),
    .lookupVpn  (lookupVpn),
    .lookupAsid (lookupAsid),
    .lookupHit  (lookupHit),
    .lookupPpn  (lookupPpn)
  );

endmodule

// File: tb/test_instr_tlb.sv
module test_instr_tlb;

  logic        clk = 1'b0;
  logic        rst;
  logic [19:0] lookupVpn;
  logic [7:0]  lookupAsid;
  logic        lookupHit;
  logic [19:0] lookupPpn;
  logic        fillValid;
  logic [19:0] fillVpn;
  logic [19:0] fillPpn;
  logic [7:0]  fillAsid;
  logic        fillGlobal;
  logic        invReq;
  logic [31:0] invOperand;
  logic        invDone;

  always #5 clk = ~clk;

  instr_tlb i_instr_tlb (
    .clk (clk), .rst (rst),
    .lookupVpn (lookupVpn), .lookupAsid (lookupAsid),
    .lookupHit (lookupHit), .lookupPpn (lookupPpn),
    .fillValid (fillValid), .fillVpn (fillVpn), .fillPpn (fillPpn),
    .fillAsid (fillAsid), .fillGlobal (fillGlobal),
    .invReq (invReq), .invOperand (invOperand), .invDone (invDone)
  );

  int checks = 0;
  int errors = 0;

  // Reference model, built from the requirements
  logic        mValid [16];
  logic [19:0] mVpn   [16];
  logic [19:0] mPpn   [16];
  logic [7:0]  mAsid  [16];
  logic        mGlb   [16];
  int          mPtr;
  logic        mBusy;
  logic        mDone;
  logic [31:0] mOp;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void modelReset();
    for (int i = 0; i < 16; i++) mValid[i] = 1'b0;
    mPtr  = 0;
    mBusy = 1'b0;
    mDone = 1'b0;
    mOp   = '0;
  endfunction

  function automatic void modelLookup(input logic [19:0] vpn, input logic [7:0] asid,
                                      output logic hit, output logic [19:0] ppn);
    hit = 1'b0;
    ppn = '0;
    for (int i = 0; i < 16; i++) begin
      if (!hit && mValid[i] && mVpn[i] == vpn && (mGlb[i] || mAsid[i] == asid)) begin
        hit = 1'b1;
        ppn = mPpn[i];
      end
    end
  endfunction

  function automatic void modelEdge();
    int victim = -1;
    bit noFree;
    for (int i = 0; i < 16; i++)
      if (!mValid[i] && victim < 0) victim = i;
    noFree = (victim < 0);
    if (noFree) victim = mPtr;
    if (mBusy) begin
      for (int i = 0; i < 16; i++)
        if (mValid[i] && mVpn[i] == mOp[31:12] && (mGlb[i] || mAsid[i] == mOp[7:0]))
          mValid[i] = 1'b0;
    end
    if (fillValid) begin
      mValid[victim] = 1'b1;
      mVpn[victim]   = fillVpn;
      mPpn[victim]   = fillPpn;
      mAsid[victim]  = fillAsid;
      mGlb[victim]   = fillGlobal;
      if (noFree) mPtr = (mPtr + 1) % 16;
    end
    mDone = mBusy;
    if (invReq && !mBusy) begin
      mOp   = invOperand;
      mBusy = 1'b1;
    end else begin
      mBusy = 1'b0;
    end
  endfunction

  task automatic cycle(input logic fv, input logic [19:0] fvpn, input logic [19:0] fppn,
                       input logic [7:0] fasid, input logic fglb,
                       input logic iv, input logic [31:0] iop,
                       input logic [19:0] lvpn, input logic [7:0] lasid,
                       input int expHit, input int expDone, input string tag);
    logic eh;
    logic [19:0] ep;
    @(negedge clk);
    fillValid = fv; fillVpn = fvpn; fillPpn = fppn; fillAsid = fasid; fillGlobal = fglb;
    invReq = iv; invOperand = iop; lookupVpn = lvpn; lookupAsid = lasid;
    #1;
    modelLookup(lvpn, lasid, eh, ep);
    check(lookupHit == eh && (!eh || lookupPpn == ep), tag,
          {lookupHit, lookupPpn}, {eh, ep});
    check(invDone == mDone, "R8 done timing", invDone, mDone);
    if (expHit >= 0) check(lookupHit == expHit[0], tag, lookupHit, expHit);
    if (expDone >= 0) check(invDone == expDone[0], "R8 done pulse", invDone, expDone);
    @(posedge clk);
    #1 modelEdge();
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                      input logic [7:0] asid, input logic glb);
    cycle(1'b1, vpn, ppn, asid, glb, 1'b0, '0, vpn, asid, -1, -1, "R7 fill");
  endtask

  task automatic probe(input logic [19:0] vpn, input logic [7:0] asid,
                       input int expHit, input string tag);
    cycle(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, vpn, asid, expHit, -1, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; fillValid = 1'b0; invReq = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1 modelReset();
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; fillValid = 1'b0; fillVpn = '0; fillPpn = '0; fillAsid = '0;
    fillGlobal = 1'b0; invReq = 1'b0; invOperand = '0; lookupVpn = '0; lookupAsid = '0;
    modelReset();
    doReset();

    // R11: empty after reset
    probe(20'h12345, 8'h05, 0, "R11 reset empty");

    // R6: lookup rules
    fill(20'h12345, 20'hA0000, 8'h05, 1'b0);
    fill(20'h12345, 20'hA0001, 8'h07, 1'b0);
    fill(20'h12345, 20'hA0002, 8'h09, 1'b1);
    fill(20'h22222, 20'hA0003, 8'h05, 1'b0);
    probe(20'h12345, 8'h05, 1, "R6 asid hit lowest index");
    check(lookupPpn == 20'hA0000, "R6 lowest ppn", lookupPpn, 20'hA0000);
    probe(20'h12345, 8'h03, 1, "R6 global hit");
    probe(20'h22222, 8'h06, 0, "R6 asid mismatch miss");

    // R1 R2 R3 R4 R8: invalidate page 12345 asid 05, reserved bits all ones
    cycle(1'b0, '0, '0, '0, 1'b0, 1'b1, {20'h12345, 4'hF, 8'h05},
          20'h12345, 8'h05, 1, 0, "R1 before apply");
    cycle(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, 20'h12345, 8'h05, 1, 0, "R8 apply cycle");
    cycle(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, 20'h12345, 8'h05, 0, 1, "R1 R2 removed");
    probe(20'h12345, 8'h05, 0, "R8 done cleared");
    check(invDone == 1'b0, "R8 done single", invDone, 0);
    probe(20'h12345, 8'h07, 1, "R3 other asid survives");
    probe(20'h12345, 8'h09, 0, "R4 global removed");
    probe(20'h22222, 8'h05, 1, "R3 other page survives");

    // R5: duplicates removed together
    fill(20'h00ABC, 20'hB0000, 8'h03, 1'b0);
    fill(20'h00ABC, 20'hB0001, 8'h03, 1'b0);
    fill(20'h00ABC, 20'hB0002, 8'h04, 1'b0);
    cycle(1'b0, '0, '0, '0, 1'b0, 1'b1, {20'h00ABC, 4'h0, 8'h03},
          20'h00ABC, 8'h03, 1, -1, "R5 before");
    probe(20'h00ABC, 8'h03, -1, "R5 apply");
    probe(20'h00ABC, 8'h03, 0, "R5 duplicates gone");
    probe(20'h00ABC, 8'h04, 1, "R5 other asid kept");

    // R9: request during apply is dropped
    cycle(1'b0, '0, '0, '0, 1'b0, 1'b1, {20'h77777, 4'h0, 8'h01},
          20'h12345, 8'h07, 1, -1, "R9 first req");
    cycle(1'b0, '0, '0, '0, 1'b0, 1'b1, {20'h12345, 4'h0, 8'h07},
          20'h12345, 8'h07, 1, -1, "R9 second req");
    probe(20'h12345, 8'h07, 1, "R9 ignored");
    probe(20'h12345, 8'h07, 1, "R9 ignored later");

    // R10: fill during apply survives
    fill(20'h33333, 20'hC0000, 8'h01, 1'b0);
    cycle(1'b0, '0, '0, '0, 1'b0, 1'b1, {20'h33333, 4'h0, 8'h01},
          20'h33333, 8'h01, 1, -1, "R10 req");
    cycle(1'b1, 20'h33333, 20'hC0001, 8'h01, 1'b0, 1'b0, '0,
          20'h33333, 8'h01, 1, -1, "R10 fill in apply");
    probe(20'h33333, 8'h01, 1, "R10 fill kept");
    check(lookupPpn == 20'hC0001, "R10 new ppn", lookupPpn, 20'hC0001);

    // R7: round-robin victim when full
    doReset();
    for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 20'hD0000 + 20'(i), 8'h02, 1'b0);
    fill(20'h00200, 20'hE0000, 8'h02, 1'b0);
    probe(20'h00100, 8'h02, 0, "R7 victim 0 replaced");
    probe(20'h00101, 8'h02, 1, "R7 entry 1 kept");
    fill(20'h00201, 20'hE0001, 8'h02, 1'b0);
    probe(20'h00101, 8'h02, 0, "R7 victim 1 replaced");
    probe(20'h00200, 8'h02, 1, "R7 new entry present");

    // R11: reset mid-run empties the cache
    doReset();
    probe(20'h00200, 8'h02, 0, "R11 reset clears");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic fv, iv, g;
      logic [19:0] v, lv;
      logic [7:0] a, la;
      fv = ($urandom_range(0, 2) == 0);
      iv = ($urandom_range(0, 3) == 0);
      g  = ($urandom_range(0, 3) == 0);
      v  = 20'($urandom_range(0, 5));
      lv = 20'($urandom_range(0, 5));
      a  = 8'($urandom_range(0, 3));
      la = 8'($urandom_range(0, 3));
      cycle(fv, v, 20'($urandom), a, g, iv,
            {20'($urandom_range(0, 5)), 4'($urandom), 8'($urandom_range(0, 3))},
            lv, la, -1, -1, "R6 random lookup");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule